// File: doc/BRIEF.md
# Multi-Prefix Add Unit

This block keeps one shared counter for a group of N requesters and performs a combined fetch-and-add on it. In a given clock cycle any subset of the requesters may raise its valid line and offer an operand. The unit adds all offered operands to the counter in one atomic step. Each active requester gets back the counter's old value plus the operands of every active requester with a lower index. Each requester therefore sees a different value, and no two simultaneous requests collide. A typical use is handing out unique slot numbers in a shared queue to several agents in the same cycle.

A separate load strobe sets the counter to a chosen starting value. A request in the same cycle as a load is served on top of the newly loaded value. The interface has no back-pressure. Requests are accepted in the cycle they are presented, with no ready signal. Each result valid bit is a one-cycle pulse, one clock after the request, and the consumer must capture it in that cycle. All sums wrap modulo 2^W.

Top module: `mpadd_unit`

## Requirements
- R1: While reset is held and after its release, `total_value` reads 0 and every bit of `res_valid` is 0.
- R2: With `init_valid` high and no request, `total_value` equals `init_value` one clock later.
- R3: One clock after a request cycle, lane j with `req_valid[j]` high returns the old counter value plus the sum of the operands of all lanes with a lower index that were valid in that cycle. Its own operand is not included. Lane j's operand and result occupy bits [j*W +: W] of the flat buses.
- R4: One clock after a request cycle, `total_value` equals the old counter value plus the sum of all valid operands.
- R5: A lane whose valid line is low adds nothing to any other lane's result or to the total, and its `res_valid` bit stays 0.
- R6: `res_valid` equals the previous cycle's `req_valid`, so each result is a pulse exactly one clock long.
- R7: When `init_valid` and requests arrive in the same cycle, `init_value` replaces the old counter value as the base of every result and of the new total.
- R8: All results and the total wrap modulo 2^W.
- R9: In a cycle with neither a load nor any request, `total_value` does not change and no `res_valid` bit is set in the next cycle.
- R10: Operations in back-to-back cycles chain: the second operation uses the total produced by the first as its base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| init_valid | input | 1 | Load strobe for the shared counter |
| init_value | input | W | Value to load |
| req_valid | input | N | Per-lane request strobe, bit j for lane j |
| req_operand | input | N*W | Per-lane operand, lane j at [j*W +: W] |
| res_valid | output | N | Per-lane result pulse |
| res_value | output | N*W | Per-lane exclusive prefix result, lane j at [j*W +: W] |
| total_value | output | W | Current value of the shared counter |

## Verification
The hardest case to reach is a sparse request mask combined with a same-cycle load and a sum that crosses the 2^W boundary. In that case gaps in the mask, the base replacement and the wrap all act on one result. The stimulus uses a narrow data width so the wrap is easy to reach. It loads a base just below the wrap point, then applies dense, sparse and single-lane masks. It also applies a request and a load in the same cycle, back-to-back operations, and a run of pseudo-random masks and operands. Every cycle's expected lane values and total are computed by an independent serial reference model.

// File: rtl/mpadd_pkg.sv
package mpadd_pkg;
  // number of doubling stages needed to span n lanes (at least one)
  function automatic int scan_levels(input int n);
    int l;
    l = 0;
    while ((1 << l) < n) l++;
    return (l < 1) ? 1 : l;
  endfunction
endpackage

// File: rtl/mpadd_lane_gate.sv
module mpadd_lane_gate #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0]          lane_en,
  input  logic [N*W-1:0]        lane_flat,
  output logic [N-1:0][W-1:0]   lane_gated
);
  // an idle lane contributes zero to every sum
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane_gated[g] = lane_en[g] ? lane_flat[g*W +: W] : '0;
  end
endmodule

// File: rtl/mpadd_scan.sv
module mpadd_scan #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic [N-1:0][W-1:0] term_in,
  output logic [N-1:0][W-1:0] excl_out,
  output logic [W-1:0]        sum_out
);
  import mpadd_pkg::*;
  localparam int LV = scan_levels(N);

  // stage s holds, per lane, the sum of up to 2^s terms ending at that lane
  logic [W-1:0] stage [0:LV][N];

  for (genvar i = 0; i < N; i++) begin : g_seed
    assign stage[0][i] = term_in[i];
  end

  for (genvar s = 0; s < LV; s++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= (1 << s)) begin : g_add
        assign stage[s+1][i] = stage[s][i] + stage[s][i-(1 << s)];
      end else begin : g_pass
        assign stage[s+1][i] = stage[s][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_excl
    if (i == 0) begin : g_first
      assign excl_out[i] = '0;
    end else begin : g_rest
      assign excl_out[i] = stage[LV][i-1];
    end
  end

  assign sum_out = stage[LV][N-1];
endmodule

// File: rtl/mpadd_unit.sv
module mpadd_unit #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_valid,
  input  logic [W-1:0]   init_value,
  input  logic [N-1:0]   req_valid,
  input  logic [N*W-1:0] req_operand,
  output logic [N-1:0]   res_valid,
  output logic [N*W-1:0] res_value,
  output logic [W-1:0]   total_value
);
  logic [N-1:0][W-1:0] gated;
  logic [N-1:0][W-1:0] excl;
  logic [W-1:0]        grand;
  logic [W-1:0]        base;
  logic [W-1:0]        total_q;
  logic [N-1:0]        vld_q;
  logic [N-1:0][W-1:0] val_q;
  logic                any_req;

  mpadd_lane_gate #(.N(N), .W(W)) u_gate (
    .lane_en   (req_valid),
    .lane_flat (req_operand),
    .lane_gated(gated)
  );

  mpadd_scan #(.N(N), .W(W)) u_scan (
    .term_in (gated),
    .excl_out(excl),
    .sum_out (grand)
  );

  assign any_req = |req_valid;
  // a same-cycle load becomes the base of this operation
  assign base    = init_valid ? init_value : total_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total_q <= '0;
      vld_q   <= '0;
      val_q   <= '0;
    end else begin
      vld_q <= req_valid;
      if (init_valid || any_req) total_q <= base + grand;
      if (any_req) begin
        for (int j = 0; j < N; j++) val_q[j] <= base + excl[j];
      end
    end
  end

  assign res_valid   = vld_q;
  assign res_value   = val_q;
  assign total_value = total_q;

  // scan output relations, checked against a serial chain
  for (genvar j = 1; j < N; j++) begin : g_chk
    a_r3_prefix_step: assert property (@(posedge clk) disable iff (!rst_n)
      excl[j] == excl[j-1] + gated[j-1]);
  end

  a_r4_sum_link: assert property (@(posedge clk) disable iff (!rst_n)
    grand == excl[N-1] + gated[N-1]);

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (init_valid && !any_req) |=> total_value == $past(init_value));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_valid && !any_req) |=> ($stable(total_value) && res_valid == '0));

  a_r7_lane0_base: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |=> res_value[W-1:0] ==
      ($past(init_valid) ? $past(init_value) : $past(total_value)));

  a_r4_total_top: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> total_value == res_value[(N-1)*W +: W] +
      ($past(req_valid[N-1]) ? $past(req_operand[(N-1)*W +: W]) : '0));

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> res_valid == $past(req_valid));
endmodule

// File: tb/mpadd_unit_test.sv
`timescale 1ns/1ps
module mpadd_unit_test;
  localparam int N = 8;
  localparam int W = 8;

  typedef struct {
    logic [N-1:0]   vmask;
    logic [N*W-1:0] vals;
    logic [W-1:0]   tot;
    string          tag;
  } exp_t;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           init_valid = 0;
  logic [W-1:0]   init_value = '0;
  logic [N-1:0]   req_valid = '0;
  logic [N*W-1:0] req_operand = '0;
  logic [N-1:0]   res_valid;
  logic [N*W-1:0] res_value;
  logic [W-1:0]   total_value;

  exp_t   sb[$];
  logic [W-1:0] model_total = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mpadd_unit #(.N(N), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_value(init_value),
    .req_valid(req_valid), .req_operand(req_operand), .res_valid(res_valid),
    .res_value(res_value), .total_value(total_value)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: one call per cycle, pushes the reference expectation
  task automatic step(input bit ini, input logic [W-1:0] iv,
                      input logic [N-1:0] m, input logic [N*W-1:0] ops,
                      input string tag);
    exp_t e;
    logic [W-1:0] acc;
    @(negedge clk);
    init_valid  = ini;
    init_value  = iv;
    req_valid   = m;
    req_operand = ops;
    acc = ini ? iv : model_total;
    e.vals = '0;
    for (int j = 0; j < N; j++) begin
      e.vals[j*W +: W] = acc;
      if (m[j]) acc = acc + ops[j*W +: W];
    end
    e.vmask = m;
    e.tot   = (ini || m != '0) ? acc : model_total;
    e.tag   = tag;
    model_total = e.tot;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(1'b0, '0, '0, '0, tag);
  endtask

  // monitor: results of the previous negedge drive appear after this edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(res_valid == e.vmask, e.tag, "res_valid", res_valid, e.vmask);
        chk(total_value == e.tot, e.tag, "total", total_value, e.tot);
        for (int j = 0; j < N; j++)
          if (e.vmask[j])
            chk(res_value[j*W +: W] == e.vals[j*W +: W], e.tag, "lane",
                res_value[j*W +: W], e.vals[j*W +: W]);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog run hung actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  function automatic logic [N*W-1:0] fill(input logic [W-1:0] a, input logic [W-1:0] inc);
    logic [N*W-1:0] r;
    for (int j = 0; j < N; j++) r[j*W +: W] = a + inc * W'(j);
    return r;
  endfunction

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(total_value == '0, "R1", "total in reset", total_value, 0);
    chk(res_valid == '0, "R1", "res_valid in reset", res_valid, 0);
    rst_n = 1;
    idle("R1");
    // R2: plain load
    step(1'b1, 8'd100, '0, '0, "R2");
    idle("R9");
    // R3/R4: all lanes, operands 1..8
    step(1'b0, '0, 8'hFF, fill(8'd1, 8'd1), "R3");
    // R5: sparse mask, invalid lanes carry garbage
    step(1'b0, '0, 8'b1010_0101, fill(8'd7, 8'd3), "R5");
    // R6/R9: idle after a request, pulse must drop
    idle("R6");
    idle("R9");
    // R7: load and request in one cycle
    step(1'b1, 8'd40, 8'b0110_0011, fill(8'd2, 8'd5), "R7");
    // R8: wrap past 2^W
    step(1'b1, 8'd250, 8'hFF, fill(8'd3, 8'd0), "R8");
    // R10: back-to-back chained operations
    step(1'b0, '0, 8'h81, fill(8'd200, 8'd1), "R10");
    step(1'b0, '0, 8'h18, fill(8'd90, 8'd7), "R10");
    step(1'b0, '0, 8'h01, fill(8'd5, 8'd0), "R4");
    idle("R9");
    // R3: pseudo-random masks and operands
    lf = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[5] & lf[9], lf[15:8], lf[7:0],
           fill(lf[11:4], lf[7:0] ^ 8'h35), "R3");
    end
    idle("R9");
    idle("R9");
    @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule